// File: doc/BRIEF.md
# Tag-Renamed Register File

This block is the architectural register file of an out-of-order core that renames registers with tags. Every register carries a valid flag and the tag of the youngest in-flight instruction that will write it. When an instruction is renamed, each of its two sources comes back either as a ready value or as the tag of the producer it must wait for. The destination register is then marked pending under a newly allocated tag.

Results arrive on a broadcast bus as a tag and a value. A pending register takes a broadcast value only when the broadcast tag equals the tag it holds. A result from a writer that a newer rename has since displaced is therefore dropped. Tags come from a small free pool. A tag returns to the pool when its result is broadcast, because at that point no pending copy of it is left.

Rename waits when the downstream reservation station has no free slot. It also waits when the instruction needs a destination tag and the pool is empty. The block does not contain the reservation stations or the arbiter for the broadcast bus.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register is valid and holds zero, and all tags are in the free pool.
- R2: While `rsFree` is low, a rename request is not accepted and no register or pool state changes.
- R3: An accepted rename with `renDstEn` high allocates the lowest-numbered free tag and reports it on `renTag`. From the next cycle the destination register is pending and holds that tag.
- R4: A source whose register is valid reads as ready with the register value. A pending source reads as not ready, with its tag zero-extended in the low bits of the data port. Sources see the register state from before a rename in the same cycle.
- R5: A broadcast whose tag equals the tag of a pending register writes the broadcast value into that register and sets it valid on the next cycle.
- R6: A broadcast leaves unchanged any register that is already valid or that holds a different tag. This includes a stale result whose register a newer rename has claimed.
- R7: When a register is renamed in the same cycle that its current tag is broadcast, the rename wins: the register stays pending under the new tag.
- R8: A pending source whose tag is being broadcast in the same cycle reads as ready, with the broadcast value.
- R9: A broadcast tag rejoins the free pool on the next cycle. A rename that needs a destination tag stalls while the pool is empty, and a rename without a destination needs no tag. Broadcasts name only tags that are currently allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | A rename request is present |
| rsFree | input | 1 | The reservation station can take an entry |
| renDstEn | input | 1 | The instruction writes a destination register |
| renDst | input | REG_W | Destination register index |
| renSrcA | input | REG_W | First source register index |
| renSrcB | input | REG_W | Second source register index |
| renAccept | output | 1 | The rename is taken this cycle |
| renTag | output | TAG_W | Tag given to the destination |
| srcAReady | output | 1 | First source value is available |
| srcAData | output | DATA_W | First source value, or its producer tag |
| srcBReady | output | 1 | Second source value is available |
| srcBData | output | DATA_W | Second source value, or its producer tag |
| bcValid | input | 1 | A result is broadcast |
| bcTag | input | TAG_W | Tag of the broadcast result |
| bcValue | input | DATA_W | Broadcast result value |

## Verification
The assertions check four things on every cycle:
- A pending register never holds a tag that is in the free pool.
- A register turns valid only through a broadcast of its own tag.
- A valid register never changes its value.
- Both stall conditions block acceptance, and allocation and return update the pool one cycle later.

Which tag is chosen, what each source port carries, and the value seen through the same-cycle bypass can only be shown by the bench's scenarios. The same holds for the outcome when a rename and a broadcast collide on one register. The bench runs these scenarios and a long mixed sweep against an arithmetic model.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic rename;  // rename accepted this cycle
    logic claim;   // destination claimed under allocTag
  } rrf_strobe_t;
endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_TAGS = 4,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic              rsFree,
  input  logic              renDstEn,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  output rrf_strobe_t       strobe,
  output logic [TAG_W-1:0]  allocTag,
  output logic              renAccept,
  output logic [NUM_TAGS-1:0] freeMask
);
  logic anyFree;
  logic [NUM_TAGS-1:0] claimVec, retVec;

  always_comb begin
    allocTag = '0;
    for (int t = NUM_TAGS - 1; t >= 0; t--)
      if (freeMask[t]) allocTag = TAG_W'(t);
    anyFree = |freeMask;
    renAccept = renValid && rsFree && (!renDstEn || anyFree);
    strobe.rename = renAccept;
    strobe.claim = renAccept && renDstEn;
    claimVec = strobe.claim ? (NUM_TAGS'(1) << allocTag) : '0;
    retVec = bcValid ? (NUM_TAGS'(1) << bcTag) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) freeMask <= '1;
    else freeMask <= (freeMask & ~claimVec) | retVec;
  end

  // R2
  rs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && !rsFree) |-> !renAccept);
  // R9
  pool_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && renDstEn && freeMask == '0) |-> !renAccept);
  // R3
  claim_leaves_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.claim |=> !freeMask[$past(allocTag)]);
  // R9
  tag_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcValid |=> freeMask[$past(bcTag)]);
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W = 2,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rrf_strobe_t       strobe,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [REG_W-1:0]  renDst,
  input  logic [REG_W-1:0]  renSrcA,
  input  logic [REG_W-1:0]  renSrcB,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcValue,
  output logic              srcAReady,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBReady,
  output logic [DATA_W-1:0] srcBData,
  output logic [NUM_REGS-1:0] validQ,
  output logic [TAG_W-1:0]  tagQ [NUM_REGS]
);
  logic [DATA_W-1:0] valQ [NUM_REGS];
  logic [REG_W-1:0] srcSel [2];
  logic rdy [2];
  logic [DATA_W-1:0] dat [2];

  assign srcSel[0] = renSrcA;
  assign srcSel[1] = renSrcB;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic hit;
    always_comb begin
      hit = bcValid && (tagQ[srcSel[p]] == bcTag);
      rdy[p] = validQ[srcSel[p]] || hit;
      if (validQ[srcSel[p]]) dat[p] = valQ[srcSel[p]];
      else if (hit) dat[p] = bcValue;
      else dat[p] = DATA_W'(tagQ[srcSel[p]]);
    end
  end

  assign srcAReady = rdy[0];
  assign srcAData = dat[0];
  assign srcBReady = rdy[1];
  assign srcBData = dat[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        valQ[i] <= '0;
        tagQ[i] <= '0;
      end
      validQ <= '1;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.claim && renDst == REG_W'(i)) begin
          validQ[i] <= 1'b0;
          tagQ[i] <= allocTag;
        end else if (bcValid && !validQ[i] && tagQ[i] == bcTag) begin
          validQ[i] <= 1'b1;
          valQ[i] <= bcValue;
        end
      end
    end
  end

  // R3
  rename_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.claim |=> !validQ[$past(renDst)] && tagQ[$past(renDst)] == $past(allocTag));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // R5
    wake_by_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(validQ[g]) |-> $past(bcValid) && $past(bcTag) == tagQ[g] && valQ[g] == $past(bcValue));
    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (validQ[g] && $past(validQ[g])) |-> $stable(valQ[g]));
  end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile
  import rrf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 16,
  parameter int NUM_TAGS = 4,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic              rsFree,
  input  logic              renDstEn,
  input  logic [REG_W-1:0]  renDst,
  input  logic [REG_W-1:0]  renSrcA,
  input  logic [REG_W-1:0]  renSrcB,
  output logic              renAccept,
  output logic [TAG_W-1:0]  renTag,
  output logic              srcAReady,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBReady,
  output logic [DATA_W-1:0] srcBData,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcValue
);
  rrf_strobe_t strobe;
  logic [NUM_TAGS-1:0] freeMask;
  logic [NUM_REGS-1:0] validQ;
  logic [TAG_W-1:0] tagQ [NUM_REGS];

  rrf_ctrl #(.NUM_TAGS(NUM_TAGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .rsFree(rsFree),
    .renDstEn(renDstEn), .bcValid(bcValid), .bcTag(bcTag),
    .strobe(strobe), .allocTag(renTag), .renAccept(renAccept),
    .freeMask(freeMask)
  );

  rrf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .allocTag(renTag),
    .renDst(renDst), .renSrcA(renSrcA), .renSrcB(renSrcB),
    .bcValid(bcValid), .bcTag(bcTag), .bcValue(bcValue),
    .srcAReady(srcAReady), .srcAData(srcAData),
    .srcBReady(srcBReady), .srcBData(srcBData),
    .validQ(validQ), .tagQ(tagQ)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_live
    // R9
    pending_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !validQ[g] |-> !freeMask[tagQ[g]]);
  end
endmodule

// File: tb/sim_rename_regfile.sv
`timescale 1ns/1ps
module sim_rename_regfile;
  localparam int NR = 8, DW = 16, NT = 4, RW = 3, TW = 2;

  logic clk = 0, rst_n = 0;
  logic renValid = 0, rsFree = 0, renDstEn = 0, bcValid = 0;
  logic [RW-1:0] renDst = 0, renSrcA = 0, renSrcB = 0;
  logic [TW-1:0] bcTag = 0;
  logic [DW-1:0] bcValue = 0;
  logic renAccept, srcAReady, srcBReady;
  logic [TW-1:0] renTag;
  logic [DW-1:0] srcAData, srcBData;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mVal [NR];
  logic mValid [NR];
  logic [TW-1:0] mTag [NR];
  logic mFree [NT];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  rename_regfile u0 (.*);

  function automatic logic [31:0] nextRng(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkSrc(string lbl, logic [RW-1:0] s, logic rdy, logic [DW-1:0] d);
    logic hit, er;
    logic [DW-1:0] ed;
    hit = bcValid && mTag[s] == bcTag;
    er = mValid[s] || hit;
    ed = mValid[s] ? mVal[s] : (hit ? bcValue : DW'(mTag[s]));
    check({lbl, " R4 R8"}, "src ready", DW'(rdy), DW'(er));
    check({lbl, " R4 R8"}, "src data", d, ed);
  endtask

  task automatic step(string lbl, logic v, logic rf, logic de, logic [RW-1:0] d,
                      logic [RW-1:0] a, logic [RW-1:0] b, logic bv,
                      logic [TW-1:0] bt, logic [DW-1:0] bval);
    logic anyF, expAcc;
    logic [TW-1:0] expTag;
    @(negedge clk);
    renValid = v; rsFree = rf; renDstEn = de; renDst = d; renSrcA = a; renSrcB = b;
    bcValid = bv; bcTag = bt; bcValue = bval;
    #1;
    anyF = 0; expTag = 0;
    for (int t = NT - 1; t >= 0; t--) if (mFree[t]) begin anyF = 1; expTag = TW'(t); end
    expAcc = v && rf && (!de || anyF);
    check({lbl, " R2 R9"}, "accept", DW'(renAccept), DW'(expAcc));
    if (expAcc && de) check({lbl, " R3"}, "tag", DW'(renTag), DW'(expTag));
    checkSrc(lbl, a, srcAReady, srcAData);
    checkSrc(lbl, b, srcBReady, srcBData);
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      if (expAcc && de && d == RW'(i)) begin mValid[i] = 0; mTag[i] = expTag; end
      else if (bv && !mValid[i] && mTag[i] == bt) begin mValid[i] = 1; mVal[i] = bval; end
    end
    if (bv) mFree[bt] = 1;
    if (expAcc && de) mFree[expTag] = 0;
  endtask

  task automatic idleRead(string lbl, logic [RW-1:0] a, logic [RW-1:0] b);
    step(lbl, 0, 1, 0, 0, a, b, 0, 0, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mVal[i] = 0; mValid[i] = 1; mTag[i] = 0; end
    for (int t = 0; t < NT; t++) mFree[t] = 1;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: every register valid with zero after reset
    for (int i = 0; i < NR; i += 2) idleRead("R1", RW'(i), RW'(i + 1));
    // R3 R4: rename r1, sources read the old state of r1
    step("R3", 1, 1, 1, 1, 1, 2, 0, 0, 0);
    idleRead("R4", 1, 1);
    // R2: reservation station full, nothing changes
    step("R2", 1, 0, 1, 2, 2, 1, 0, 0, 0);
    idleRead("R2", 2, 1);
    // R6: r1 renamed again to tag 1, stale tag 0 result dropped
    step("R6", 1, 1, 1, 1, 1, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 0, 1, 0, 1, 0, 16'hBEEF);
    idleRead("R6", 1, 0);
    // R8: bypass when tag 1 is broadcast while r1 is read
    step("R8", 0, 1, 0, 0, 1, 3, 1, 1, 16'h0055);
    // R5: r1 now holds the value
    idleRead("R5", 1, 1);
    // R9: fill the pool, then stall a rename needing a tag
    step("R9", 1, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 1, 2, 0, 2, 0, 0, 0);
    step("R9", 1, 1, 1, 3, 2, 3, 0, 0, 0);
    step("R9", 1, 1, 1, 4, 4, 3, 0, 0, 0);
    step("R9", 1, 1, 1, 5, 4, 5, 0, 0, 0);
    step("R9", 1, 1, 0, 0, 0, 4, 0, 0, 0);
    // return tag 3 (r4), then R7 collision on r0 (tag 0)
    step("R9", 0, 1, 0, 0, 4, 4, 1, 3, 16'h0444);
    step("R7", 1, 1, 1, 0, 0, 4, 1, 0, 16'h0AAA);
    idleRead("R7", 0, 4);
    // mixed sweep
    for (int n = 0; n < 4000; n++) begin
      logic bv;
      logic [TW-1:0] bt;
      logic [RW-1:0] d, a, b;
      rng = nextRng(rng);
      bv = 0; bt = 0;
      if (rng[20:19] != 0)
        for (int k = 0; k < NT; k++) begin
          logic [TW-1:0] c;
          c = TW'(rng[22:21] + TW'(k));
          if (!bv && !mFree[c]) begin bv = 1; bt = c; end
        end
      d = rng[2:0]; a = rng[5:3]; b = rng[8:6];
      step("mix", rng[9] | rng[10], rng[11] | rng[12] | rng[13], rng[14] | rng[15],
           d, a, b, bv, bt, rng[31:16]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule